// File: doc/BRIEF.md
# Row Blanking and Calibration Sequencer

Between the readout of two consecutive sensor rows there is a blanking gap. This block times that gap and runs the output amplifier calibration inside it. A row-start request that arrives while the block is idle opens a blanking interval. The length of the interval in system clocks comes from a two-bit granularity code. The code picks the sequencer clock multiple: 2, 4, 8 or 16 system clocks. A fast-reset setting overrides the code and forces the shortest interval.

Each interval begins with a one-cycle calibration strobe. A calibration mode output runs alongside it, where 0 means a fast one-shot calibration and 1 means a slow incremental one. The mode comes from a frame-level bit on the first row of a frame and from a line-level bit on every later row. All configuration is captured when the interval opens, so the surrounding row sequencer may change it freely while blanking is in progress.

Top module: `row_blank_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, blank_active_o, blank_done_o and cal_strobe_o are 0 and cal_mode_o is 0.
- R2: A row_start_i sampled high at a clock edge while idle makes blank_active_o high from the cycle after that edge.
- R3: blank_active_o stays high for exactly UNIT_CYC*2^(code+1)+EXTRA_CYC consecutive cycles, where code is gran_i. With the defaults, codes 0, 1, 2 and 3 give 142, 282, 562 and 1122 cycles.
- R4: When fast_reset_i is 1 at the start of an interval, the interval has the length of code 0, whatever gran_i holds.
- R5: cal_strobe_o is high for exactly one cycle per interval, namely the first cycle in which blank_active_o is high.
- R6: During an interval, cal_mode_o equals frame_cal_i if frame_first_i was 1 at the start edge, and line_cal_i otherwise. Value 0 selects fast calibration and 1 selects slow calibration.
- R7: gran_i, fast_reset_i, frame_first_i, frame_cal_i and line_cal_i are sampled only at the start edge. Changing them during an interval alters neither its length nor cal_mode_o.
- R8: A row_start_i high while blank_active_o is high is ignored. It neither restarts nor extends the interval, and it raises no extra strobe.
- R9: blank_done_o is high for exactly one cycle, the last cycle of the interval. A row_start_i in that cycle is ignored, while a row_start_i in the following idle cycle opens a new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start_i | input | 1 | Request to open a blanking interval |
| frame_first_i | input | 1 | The requested row is the first of its frame |
| gran_i | input | GRAN_W | Sequencer clock granularity code |
| fast_reset_i | input | 1 | Force the shortest granularity |
| frame_cal_i | input | 1 | Calibration mode for the first row of a frame |
| line_cal_i | input | 1 | Calibration mode for every later row |
| blank_active_o | output | 1 | Blanking interval in progress |
| blank_done_o | output | 1 | Last cycle of the blanking interval |
| cal_strobe_o | output | 1 | One-cycle calibration trigger |
| cal_mode_o | output | 1 | Calibration mode: 0 fast, 1 slow |

## Verification
The bench builds the block with its default parameters (UNIT_CYC 70, EXTRA_CYC 2, two-bit code). The real interval lengths of 142 to 1122 cycles are therefore measured directly for every code, including the largest counter value. Because the intervals are short enough, the bench can also change the configuration and inject requests in the middle of an interval, in its last cycle and in the first idle cycle after it.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic {
    RSQ_IDLE  = 1'b0,
    RSQ_BLANK = 1'b1
  } rsq_state_e;

  // Interval length in system clocks for one granularity code.
  function automatic int unsigned rsq_interval_len(int unsigned unit_cyc,
                                                   int unsigned extra_cyc,
                                                   int unsigned code);
    return unit_cyc * (2 << code) + extra_cyc;
  endfunction

endpackage

// File: rtl/rsq_len_sel.sv
module rsq_len_sel #(
  parameter int unsigned UNIT_CYC  = 70,
  parameter int unsigned EXTRA_CYC = 2,
  parameter int unsigned GRAN_W    = 2,
  parameter int unsigned CNT_W     = 11
) (
  input  logic [GRAN_W-1:0] gran_i,
  input  logic              fast_reset_i,
  output logic [CNT_W-1:0]  load_o
);
  import rsq_pkg::*;

  localparam int unsigned NUM_GRAN = 1 << GRAN_W;

  logic [CNT_W-1:0]  len_tab [NUM_GRAN];
  logic [GRAN_W-1:0] eff_code;

  // One entry per granularity code, holding the length minus one.
  for (genvar g = 0; g < NUM_GRAN; g++) begin : g_tab
    assign len_tab[g] = CNT_W'(rsq_interval_len(UNIT_CYC, EXTRA_CYC, g) - 1);
  end

  always_comb begin
    eff_code = fast_reset_i ? '0 : gran_i;
    load_o   = len_tab[eff_code];
  end

endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (run_i && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rsq_cal_sel.sv
module rsq_cal_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic frame_first_i,
  input  logic frame_cal_i,
  input  logic line_cal_i,
  output logic mode_o
);

  logic mode_q, mode_d;

  always_comb begin
    mode_d = frame_first_i ? frame_cal_i : line_cal_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (load_i) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic row_start_i,
  input  logic zero_i,
  output logic load_o,
  output logic active_o,
  output logic strobe_o,
  output logic done_o
);
  import rsq_pkg::*;

  rsq_state_e state_q, state_d;
  logic       first_q, first_d;
  logic       start;

  always_comb begin
    start   = (state_q == RSQ_IDLE) && row_start_i;
    state_d = state_q;
    unique case (state_q)
      RSQ_IDLE:  if (row_start_i) state_d = RSQ_BLANK;
      RSQ_BLANK: if (zero_i)      state_d = RSQ_IDLE;
      default:                    state_d = RSQ_IDLE;
    endcase
    first_d = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RSQ_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  assign load_o   = start;
  assign active_o = (state_q == RSQ_BLANK);
  assign strobe_o = first_q;
  assign done_o   = (state_q == RSQ_BLANK) && zero_i;

endmodule

// File: rtl/row_blank_seq.sv
module row_blank_seq #(
  parameter int unsigned UNIT_CYC  = 70,
  parameter int unsigned EXTRA_CYC = 2,
  parameter int unsigned GRAN_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_start_i,
  input  logic              frame_first_i,
  input  logic [GRAN_W-1:0] gran_i,
  input  logic              fast_reset_i,
  input  logic              frame_cal_i,
  input  logic              line_cal_i,
  output logic              blank_active_o,
  output logic              blank_done_o,
  output logic              cal_strobe_o,
  output logic              cal_mode_o
);

  localparam int unsigned NUM_GRAN = 1 << GRAN_W;
  localparam int unsigned MAX_LEN  = UNIT_CYC * (2 << (NUM_GRAN - 1)) + EXTRA_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

  logic             load;
  logic             zero;
  logic [CNT_W-1:0] load_val;

  rsq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_start_i (row_start_i),
    .zero_i      (zero),
    .load_o      (load),
    .active_o    (blank_active_o),
    .strobe_o    (cal_strobe_o),
    .done_o      (blank_done_o)
  );

  rsq_len_sel #(
    .UNIT_CYC  (UNIT_CYC),
    .EXTRA_CYC (EXTRA_CYC),
    .GRAN_W    (GRAN_W),
    .CNT_W     (CNT_W)
  ) u_len (
    .gran_i       (gran_i),
    .fast_reset_i (fast_reset_i),
    .load_o       (load_val)
  );

  rsq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .run_i      (blank_active_o),
    .zero_o     (zero)
  );

  rsq_cal_sel u_cal (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load),
    .frame_first_i (frame_first_i),
    .frame_cal_i   (frame_cal_i),
    .line_cal_i    (line_cal_i),
    .mode_o        (cal_mode_o)
  );

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int unsigned MAX_LEN = 1122
) (
  input logic clk,
  input logic rst_n,
  input logic row_start_i,
  input logic blank_active_o,
  input logic blank_done_o,
  input logic cal_strobe_o,
  input logic cal_mode_o
);

  // Run length of the current interval, used to bound it without deep $past.
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (blank_active_o) begin
      run_q <= run_q + 1;
    end else begin
      run_q <= '0;
    end
  end

  // R3: no interval exceeds the longest configured length
  assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= MAX_LEN);

  // R5: strobe only inside an interval and never two cycles in a row
  assert_strobe_in_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_strobe_o |-> blank_active_o);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_strobe_o |=> !cal_strobe_o);
  assert_strobe_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_active_o) |-> cal_strobe_o);

  // R7: mode held for the whole interval
  assert_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_active_o && !cal_strobe_o) |-> $stable(cal_mode_o));

  // R8: a request inside an interval raises no strobe
  assert_ignore_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_active_o && row_start_i) |=> !cal_strobe_o);

  // R9: done marks the last cycle
  assert_done_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_done_o |-> (blank_active_o ##1 !blank_active_o));
  assert_done_before_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_active_o) |-> $past(blank_done_o));

endmodule

bind row_blank_seq rsq_checker #(
  .MAX_LEN (MAX_LEN)
) u_rsq_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .row_start_i    (row_start_i),
  .blank_active_o (blank_active_o),
  .blank_done_o   (blank_done_o),
  .cal_strobe_o   (cal_strobe_o),
  .cal_mode_o     (cal_mode_o)
);

// File: tb/tb_row_blank_seq.sv
`timescale 1ns/1ps
module tb_row_blank_seq;

  localparam int unsigned UNIT  = 70;
  localparam int unsigned EXTRA = 2;

  logic       clk;
  logic       rst_n;
  logic       row_start_i;
  logic       frame_first_i;
  logic [1:0] gran_i;
  logic       fast_reset_i;
  logic       frame_cal_i;
  logic       line_cal_i;
  logic       blank_active_o;
  logic       blank_done_o;
  logic       cal_strobe_o;
  logic       cal_mode_o;

  int checks;
  int failures;
  int cycles;

  row_blank_seq dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .row_start_i    (row_start_i),
    .frame_first_i  (frame_first_i),
    .gran_i         (gran_i),
    .fast_reset_i   (fast_reset_i),
    .frame_cal_i    (frame_cal_i),
    .line_cal_i     (line_cal_i),
    .blank_active_o (blank_active_o),
    .blank_done_o   (blank_done_o),
    .cal_strobe_o   (cal_strobe_o),
    .cal_mode_o     (cal_mode_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_len(int code);
    return UNIT * (2 << code) + EXTRA;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Opens one interval and measures it. disturb: change config and inject
  // a request mid-interval (R7, R8).
  task automatic run_row(string req, int code, bit fr, bit first, bit fbit,
                         bit lbit, int len_exp, bit mode_exp, bit disturb);
    int n;
    int strobes;
    int dones;
    int done_at;
    bit mode_ok;
    @(negedge clk);
    gran_i = code[1:0]; fast_reset_i = fr; frame_first_i = first;
    frame_cal_i = fbit; line_cal_i = lbit; row_start_i = 1'b1;
    @(negedge clk);
    row_start_i = 1'b0;
    check({req, " R2 active after start"}, blank_active_o, 1);
    n = 0; strobes = 0; dones = 0; done_at = 0; mode_ok = 1'b1;
    while (blank_active_o && n < 5000) begin
      n++;
      if (cal_strobe_o) strobes++;
      if (blank_done_o) begin dones++; done_at = n; end
      if (cal_mode_o != mode_exp) mode_ok = 1'b0;
      if (disturb && n == 10) begin
        gran_i = ~code[1:0]; fast_reset_i = ~fr; frame_first_i = ~first;
        frame_cal_i = ~fbit; line_cal_i = ~lbit; row_start_i = 1'b1;
      end
      if (disturb && n == 12) row_start_i = 1'b0;
      @(negedge clk);
    end
    check({req, " R3 length"}, n, len_exp);
    check({req, " R5 strobe count"}, strobes, 1);
    check({req, " R9 done count"}, dones, 1);
    check({req, " R9 done position"}, done_at, len_exp);
    check({req, " R6 cal mode"}, mode_ok, 1);
    row_start_i = 1'b0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    row_start_i = 1'b0; frame_first_i = 1'b0; gran_i = 2'd0;
    fast_reset_i = 1'b0; frame_cal_i = 1'b1; line_cal_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 active in reset", blank_active_o, 0);
    check("R1 done in reset", blank_done_o, 0);
    check("R1 strobe in reset", cal_strobe_o, 0);
    check("R1 mode in reset", cal_mode_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", blank_active_o, 0);
  endtask

  task automatic test_codes();
    for (int c = 0; c < 4; c++) begin
      run_row("R3 code", c, 1'b0, 1'b0, 1'b0, 1'b1, exp_len(c), 1'b1, 1'b0);
    end
  endtask

  task automatic test_fast_reset();
    run_row("R4 fast reset", 3, 1'b1, 1'b0, 1'b0, 1'b0, exp_len(0), 1'b0, 1'b0);
    run_row("R4 fast reset", 2, 1'b1, 1'b1, 1'b1, 1'b0, exp_len(0), 1'b1, 1'b0);
  endtask

  task automatic test_cal_modes();
    run_row("R6 first frame bit 0", 0, 1'b0, 1'b1, 1'b0, 1'b1, exp_len(0), 1'b0, 1'b0);
    run_row("R6 first frame bit 1", 0, 1'b0, 1'b1, 1'b1, 1'b0, exp_len(0), 1'b1, 1'b0);
    run_row("R6 later line bit 0", 1, 1'b0, 1'b0, 1'b1, 1'b0, exp_len(1), 1'b0, 1'b0);
  endtask

  task automatic test_disturb();
    run_row("R7 R8 disturb", 1, 1'b0, 1'b1, 1'b1, 1'b0, exp_len(1), 1'b1, 1'b1);
    run_row("R7 R8 disturb", 0, 1'b1, 1'b0, 1'b0, 1'b1, exp_len(0), 1'b1, 1'b1);
  endtask

  // R9: request on the last cycle is ignored; in the next idle cycle it is taken.
  task automatic test_back_to_back();
    int n;
    @(negedge clk);
    gran_i = 2'd0; fast_reset_i = 1'b0; frame_first_i = 1'b0;
    line_cal_i = 1'b0; row_start_i = 1'b1;
    @(negedge clk);
    row_start_i = 1'b0;
    n = 1;
    while (!blank_done_o && n < 5000) begin @(negedge clk); n++; end
    check("R9 done reached at length", n, exp_len(0));
    row_start_i = 1'b1;            // sampled in the last cycle
    @(negedge clk);
    row_start_i = 1'b0;
    check("R9 request on last cycle ignored", blank_active_o, 0);
    row_start_i = 1'b1;            // sampled while idle
    @(negedge clk);
    row_start_i = 1'b0;
    check("R9 request in idle cycle accepted", blank_active_o, 1);
    check("R9 R5 strobe on new interval", cal_strobe_o, 1);
    n = 0;
    while (blank_active_o && n < 5000) begin @(negedge clk); n++; end
    check("R9 second interval length", n, exp_len(0));
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0;
    test_reset();
    test_codes();
    test_fast_reset();
    test_cal_modes();
    test_disturb();
    test_back_to_back();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule